// File: doc/BRIEF.md
# Core Module System Control Registers

A word-addressed register block that sits beside a processor core and gathers its housekeeping state: two oscillator setting words behind a 16-bit unlock key, a control word that drives an LED, selects whether RAM or boot flash answers at address zero, and can request a system reset, two flag words with separate set and clear addresses, a free-running reference counter that software can load, and a one-source interrupt unit whose software interrupt can be routed to the IRQ line, the FIQ line, or both.

The bus carries a byte address, a write strobe, a read strobe and 32-bit data. The word index is the byte address shifted right by two, so the two lowest address bits are ignored. Reads are registered: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value until the next read.

Top module: `cm_sysctl`

## Requirements
- R1: The word index is `addr >> 2`. Words that are not listed below read as zero. Voltage words 32 to 35 and the other unlisted words ignore writes.
- R2: A write to word 5 keeps only bits 15:0 as the key. Reading word 5 returns the key in bits 15:0, and bit 16 is set exactly when the key equals 0xA05F. The key resets to 0.
- R3: Writes to word 2 (oscillator) and word 7 (auxiliary oscillator) take effect only while the key equals 0xA05F. Their reset values are 0x01000048 and 0x0007FEFF.
- R4: A write to word 3 stores bit 0, which drives `led`, and bit 2, which drives `remap_ram`. Reading word 3 returns only these two bits. Both reset to 0.
- R5: A write to word 3 with bit 3 set raises `reset_req` for exactly the one cycle after that write edge. Bit 3 always reads back as 0.
- R6: Words 8 and 9 are plain read/write words. They reset to 0x00011122 and 0x00000112.
- R7: Word 12 ORs the written value into the flags and word 13 clears the written bits. Words 14 and 15 do the same for the second flag word. The flags read at words 12 and 14 and reset to 0.
- R8: Word 10 reads a 32-bit counter that advances by one every TICK_DIV clocks and wraps at 2^32. A write loads the counter and restarts the divider, so a read k+1 cycles after the read that follows the write returns the written value + floor((k+1)/TICK_DIV).
- R9: Words 18 and 26 OR bits into the 32-bit IRQ and FIQ enable words, and words 19 and 27 clear the written bits. The enables read at words 18 and 26.
- R10: A write to word 20 with bit 0 set raises the software interrupt, which is raw level bit 0. A write to word 21 with bit 0 set clears it. Words 17, 20 and 25 read the raw level, which is zero above bit 0.
- R11: Word 16 reads raw level AND the IRQ enable word, and word 24 reads raw level AND the FIQ enable word.
- R12: `irq` is the OR of raw level AND the IRQ enable word, and `fiq` is the same with the FIQ enable word. Both are registered and change on the second rising edge after the write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| remap_ram | output | 1 | High when RAM, rather than boot flash, answers at address zero |
| led | output | 1 | LED drive |
| reset_req | output | 1 | Single-cycle reset request |
| irq | output | 1 | Interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the bus inputs are settled at each rising edge and that `rst_n` is held for at least one edge. The bench drives every input on the falling edge and reads outputs on the following falling edge, so each value is stable around the capture edge. The bench sweeps the whole 64-word map while locked, then while unlocked, then locked again, and compares every readable word with a shadow model built from the requirements. It also checks the port outputs after every write. The counter word is tested separately at known cycle distances, because its value depends on time.

// File: rtl/cm_sysctl.sv
module cm_sysctl #(
  parameter int          ADDR_W   = 8,
  parameter int          TICK_DIV = 1,
  parameter logic [15:0] LOCK_KEY = 16'hA05F,
  parameter logic [31:0] OSC_RST  = 32'h0100_0048,
  parameter logic [31:0] AUX_RST  = 32'h0007_FEFF,
  parameter logic [31:0] SDR_RST  = 32'h0001_1122,
  parameter logic [31:0] INI_RST  = 32'h0000_0112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              remap_ram,
  output logic              led,
  output logic              reset_req,
  output logic              irq,
  output logic              fiq
);
  localparam logic [ADDR_W-1:0] W_OSC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W_CTL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] W_KEY  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] W_AUX  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] W_SDR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] W_INI  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] W_CNT  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] W_FSET = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] W_FCLR = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] W_NSET = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] W_NCLR = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] W_ISTA = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] W_IRAW = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] W_IEN  = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] W_IDIS = ADDR_W'(19);
  localparam logic [ADDR_W-1:0] W_SSET = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] W_SCLR = ADDR_W'(21);
  localparam logic [ADDR_W-1:0] W_FSTA = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] W_FRAW = ADDR_W'(25);
  localparam logic [ADDR_W-1:0] W_FEN  = ADDR_W'(26);
  localparam logic [ADDR_W-1:0] W_FDIS = ADDR_W'(27);

  logic [ADDR_W-1:0] widx;
  logic [31:0] osc_q, aux_q, sdr_q, ini_q, cnt_q, flags_q, nv_q, ien_q, fen_q;
  logic [15:0] key_q;
  logic        lvl_q, unlocked, cnt_wr, tick;
  logic [31:0] raw, rd_mux;

  assign widx     = addr >> 2;
  assign unlocked = (key_q == LOCK_KEY);
  assign cnt_wr   = wr_en && (widx == W_CNT);
  assign raw      = {31'd0, lvl_q};

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || cnt_wr || tick) pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q <= OSC_RST;  aux_q <= AUX_RST;  sdr_q <= SDR_RST;  ini_q <= INI_RST;
      key_q <= '0;       cnt_q <= '0;       flags_q <= '0;     nv_q <= '0;
      ien_q <= '0;       fen_q <= '0;       lvl_q <= 1'b0;
      led <= 1'b0;       remap_ram <= 1'b0; reset_req <= 1'b0;
      irq <= 1'b0;       fiq <= 1'b0;
    end else begin
      reset_req <= wr_en && (widx == W_CTL) && wdata[3];
      irq       <= |(raw & ien_q);
      fiq       <= |(raw & fen_q);
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_q + 32'd1;
      if (wr_en) begin
        case (widx)
          W_OSC:  if (unlocked) osc_q <= wdata;
          W_AUX:  if (unlocked) aux_q <= wdata;
          W_CTL:  begin led <= wdata[0]; remap_ram <= wdata[2]; end
          W_KEY:  key_q   <= wdata[15:0];
          W_SDR:  sdr_q   <= wdata;
          W_INI:  ini_q   <= wdata;
          W_FSET: flags_q <= flags_q | wdata;
          W_FCLR: flags_q <= flags_q & ~wdata;
          W_NSET: nv_q    <= nv_q | wdata;
          W_NCLR: nv_q    <= nv_q & ~wdata;
          W_IEN:  ien_q   <= ien_q | wdata;
          W_IDIS: ien_q   <= ien_q & ~wdata;
          W_FEN:  fen_q   <= fen_q | wdata;
          W_FDIS: fen_q   <= fen_q & ~wdata;
          W_SSET: if (wdata[0]) lvl_q <= 1'b1;
          W_SCLR: if (wdata[0]) lvl_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      W_OSC:          rd_mux = osc_q;
      W_CTL:          rd_mux = {29'd0, remap_ram, 1'b0, led};
      W_KEY:          rd_mux = {15'd0, unlocked, key_q};
      W_AUX:          rd_mux = aux_q;
      W_SDR:          rd_mux = sdr_q;
      W_INI:          rd_mux = ini_q;
      W_CNT:          rd_mux = cnt_q;
      W_FSET:         rd_mux = flags_q;
      W_NSET:         rd_mux = nv_q;
      W_ISTA:         rd_mux = raw & ien_q;
      W_FSTA:         rd_mux = raw & fen_q;
      W_IRAW, W_FRAW,
      W_SSET:         rd_mux = raw;
      W_IEN:          rd_mux = ien_q;
      W_FEN:          rd_mux = fen_q;
      default:        rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(osc_q) && $stable(aux_q)));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(led) && $stable(remap_ram)));
  a_r5_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en));
  a_r7_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_FSET) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r12_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ien_q[0] == 1'b0) |-> !irq);
  a_r12_fiq_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fen_q[0] == 1'b0) |-> !fiq);
endmodule

// File: tb/cm_sysctl_tb.sv
module cm_sysctl_tb;
  localparam int CLK_P = 10;
  localparam int DIV   = 3;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic remap_ram, led, reset_req, irq, fiq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cm_sysctl #(.ADDR_W(8), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .remap_ram(remap_ram), .led(led),
    .reset_req(reset_req), .irq(irq), .fiq(fiq));

  logic [31:0] m_osc, m_aux, m_sdr, m_ini, m_fl, m_nv, m_ien, m_fen;
  logic [15:0] m_key;
  logic m_led, m_rmp, m_lvl;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void mdl_reset();
    m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF; m_sdr = 32'h0001_1122;
    m_ini = 32'h0000_0112; m_fl = 0; m_nv = 0; m_ien = 0; m_fen = 0;
    m_key = 0; m_led = 0; m_rmp = 0; m_lvl = 0;
  endfunction

  function automatic void mdl_wr(int w, logic [31:0] d);
    case (w)
      2:  if (m_key == 16'hA05F) m_osc = d;
      7:  if (m_key == 16'hA05F) m_aux = d;
      3:  begin m_led = d[0]; m_rmp = d[2]; end
      5:  m_key = d[15:0];
      8:  m_sdr = d;
      9:  m_ini = d;
      12: m_fl = m_fl | d;
      13: m_fl = m_fl & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      18: m_ien = m_ien | d;
      19: m_ien = m_ien & ~d;
      26: m_fen = m_fen | d;
      27: m_fen = m_fen & ~d;
      20: if (d[0]) m_lvl = 1'b1;
      21: if (d[0]) m_lvl = 1'b0;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int w);
    logic [31:0] r = {31'd0, m_lvl};
    case (w)
      2: return m_osc;
      3: return {29'd0, m_rmp, 1'b0, m_led};
      5: return {15'd0, m_key == 16'hA05F, m_key};
      7: return m_aux;
      8: return m_sdr;
      9: return m_ini;
      12: return m_fl;
      14: return m_nv;
      16: return r & m_ien;
      24: return r & m_fen;
      17, 20, 25: return r;
      18: return m_ien;
      26: return m_fen;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(int w);
    case (w)
      2, 7: return "R3";   3: return "R4";   5: return "R2";
      8, 9: return "R6";   12, 14: return "R7";
      16, 24: return "R11"; 17, 20, 25: return "R10";
      18, 26: return "R9"; default: return "R1";
    endcase
  endfunction

  task automatic wr(int w, logic [31:0] d);
    wr_en = 1'b1; addr = 8'(w << 2); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int w, int lowbits, output logic [31:0] d);
    rd_en = 1'b1; addr = 8'((w << 2) | lowbits);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic sweep_read(int lowbits);
    logic [31:0] d;
    for (int w = 0; w < 64; w++) begin
      if (w == 10) continue;
      rd(w, lowbits, d);
      chk(tag(w), d, exp_rd(w));
    end
  endtask

  task automatic sweep_write(logic [31:0] seed);
    for (int w = 0; w < 64; w++) begin
      logic [31:0] d = (32'(w) + seed) * 32'h9E37_79B9;
      if (w == 10 || w == 5) continue;
      wr(w, d);
      mdl_wr(w, d);
      if (w == 3) chk("R5 pulse", {31'd0, reset_req}, {31'd0, d[3]});
      @(negedge clk);
      chk("R5 single", {31'd0, reset_req}, 32'd0);
      chk("R4 led", {31'd0, led}, {31'd0, m_led});
      chk("R4 remap", {31'd0, remap_ram}, {31'd0, m_rmp});
      chk("R12 irq", {31'd0, irq}, {31'd0, m_lvl & m_ien[0]});
      chk("R12 fiq", {31'd0, fiq}, {31'd0, m_lvl & m_fen[0]});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R4 led reset", {31'd0, led}, 32'd0);
    chk("R12 irq reset", {31'd0, irq}, 32'd0);
    sweep_read(0);

    sweep_write(32'd1);
    sweep_read(3);

    wr(5, 32'h1234_A05F); mdl_wr(5, 32'h1234_A05F);
    rd(5, 0, d); chk("R2 unlock", d, 32'h0001_A05F);
    sweep_write(32'd77);
    sweep_read(1);

    wr(5, 32'h0000_A05E); mdl_wr(5, 32'h0000_A05E);
    sweep_write(32'd5);
    sweep_read(2);

    wr(18, 32'h1); mdl_wr(18, 32'h1);
    wr(26, 32'h0); mdl_wr(26, 32'h0);
    wr(21, 32'h1); mdl_wr(21, 32'h1);
    @(negedge clk);
    wr(20, 32'h1); mdl_wr(20, 32'h1);
    chk("R12 irq delay", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R12 irq set", {31'd0, irq}, 32'd1);
    rd(16, 0, d); chk("R11 status", d, 32'd1);
    wr(3, 32'h8); mdl_wr(3, 32'h8);
    chk("R5 bit3 pulse", {31'd0, reset_req}, 32'd1);
    rd(3, 0, d); chk("R5 bit3 reads 0", d, 32'd0);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] v = 32'h0000_1000 + 32'(k) * 32'h111;
      wr(10, v);
      rd(10, 0, d); chk("R8 load", d, v);
      repeat (k) @(negedge clk);
      rd(10, 0, d); chk("R8 rate", d, v + 32'((k + 1) / DIV));
    end
    wr(10, 32'hFFFF_FFFE);
    rd(10, 0, d);
    repeat (5) @(negedge clk);
    rd(10, 0, d); chk("R8 wrap", d, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule